// File: doc/BRIEF.md
# Slave-side bus acquisition controller

This block lets a secondary processor borrow a shared external memory bus that another device owns. The bus is released and the control strobes are high-impedance whenever the block has no work. An internal requester hands it access jobs through a small port: a request pulse with a flag for DRAM-type cycles, a ready signal that shows whether a job can be taken, and a one-cycle acknowledge for each job that completes.

When a job is waiting, the block drops an active-low request line to the owner and samples the owner's active-low grant on every rising edge. A grant seen on two edges in a row starts the sequence. The strobes are first driven at their inactive level, then toggled for a fixed number of access cycles. For DRAM-type jobs the block waits for a precharge-complete input. Afterwards it either chains the next queued job without arbitrating again or hands the bus back. To hand it back, it raises the request line while the strobes sit inactive, then stops driving them on the following edge.

Refresh, memory mode setup and power-down sequencing belong to the bus owner. The block has no inputs for them.

Top module: `bus_borrow_ctrl`

## Requirements
- R1: After reset `bus_req_n` is 1, `ctl_oe` is 0, `ctl_n` is all ones, `acc_ready` is 1 and `acc_ack` is 0. `ctl_oe` is never 1 while the controller is idle.
- R2: A job accepted on a rising edge while the bus is released drives `bus_req_n` to 0 after that same edge. `bus_req_n` stays 0 until release.
- R3: If `bus_gnt_n` is sampled 0 on edges k and k+1, `ctl_oe` becomes 1 after edge k+2 with `ctl_n` all ones. Before that edge it stays 0.
- R4: A grant sampled 0 on only one edge, followed by a 1, is ignored. `ctl_oe` stays 0, `bus_req_n` stays 0, and the block waits for a new two-edge grant.
- R5: The access phase starts on the edge after the strobes are first driven and lasts ACC_CYCLES cycles. In access cycle c (counted from 0), strobe bit i is 0 exactly when c >= i. Outside the access phase `ctl_n` is all ones.
- R6: On the edge that ends a non-DRAM job with no chaining, `bus_req_n` goes to 1 while `ctl_oe` stays 1 and `ctl_n` is all ones. On the next edge `ctl_oe` returns to 0.
- R7: For a job flagged DRAM (`acc_dram`=1), the block holds `ctl_oe`=1, `ctl_n` all ones and `bus_req_n`=0 after the access phase until `pre_done` is sampled 1. That edge completes the job.
- R8: Each completed job gives `acc_ack`=1 for exactly one cycle, the cycle right after its completion edge. The number of acknowledges equals the number of accepted jobs.
- R9: At most QDEPTH (default 2) jobs can be outstanding. `acc_ready` is 0 when that many are held, and a request made while `acc_ready` is 0 is dropped.
- R10: If another job is outstanding, or arrives on the completion edge, and `bus_gnt_n` is sampled 0 on that edge, the block keeps `bus_req_n` at 0. It drives inactive strobes for one cycle and starts the next access phase on the following edge, with no new arbitration.
- R11: If `bus_gnt_n` is sampled 1 on a completion edge, the block releases as in R6 even with work pending. It then asserts `bus_req_n` again one edge after `ctl_oe` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything acts on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_req | input | 1 | Internal job request, taken on an edge when `acc_ready` is 1 |
| acc_dram | input | 1 | Job needs a precharge wait (DRAM-type cycle) |
| acc_ready | output | 1 | A job can be accepted |
| acc_ack | output | 1 | One-cycle pulse per completed job |
| bus_req_n | output | 1 | Bus request to the owner, active low |
| bus_gnt_n | input | 1 | Bus grant from the owner, active low |
| ctl_n | output | NSTB | Bus control strobe values, active low |
| ctl_oe | output | 1 | Output enable for `ctl_n`; 0 means high-impedance |
| pre_done | input | 1 | Precharge complete for DRAM-type jobs |

## Verification
The bound checker watches several rules on every cycle. It checks that the enable is off in the idle state, and that every rise of the enable is preceded by two sampled grant edges. It checks that the enable drops one edge after the request line rises, and that strobes are inactive whenever the request is withdrawn. It also checks that the precharge wait cannot be left without `pre_done`, that acknowledges are single pulses, and that the queue bound holds. Only the bench scenarios can show the exact edge on which each event lands: the short-grant rejection, the staggered strobe pattern and its length, chaining without re-arbitration, re-arbitration after a lost grant, and the match between acknowledges and accepted jobs under random grant and precharge timing.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_GW1     = 3'd2,
    ST_GW2     = 3'd3,
    ST_DRIVE   = 3'd4,
    ST_ACCESS  = 3'd5,
    ST_PRE     = 3'd6,
    ST_RELEASE = 3'd7
  } bbc_state_e;

  // Request line held low in these states.
  function automatic logic holds_request(bbc_state_e s);
    return (s == ST_REQ) || (s == ST_GW1) || (s == ST_GW2) ||
           (s == ST_DRIVE) || (s == ST_ACCESS) || (s == ST_PRE);
  endfunction

  // Strobes driven (not high-impedance) in these states.
  function automatic logic drives_bus(bbc_state_e s);
    return (s == ST_DRIVE) || (s == ST_ACCESS) ||
           (s == ST_PRE) || (s == ST_RELEASE);
  endfunction

  // Work left after the current job retires: queued entries beyond the
  // head, or a job arriving on the same edge.
  function automatic logic work_after_pop(int unsigned outstanding, logic arriving);
    return (outstanding > 1) || arriving;
  endfunction

  // Staggered strobe rule: strobe bit idx is active from access cycle idx on.
  function automatic logic strobe_active(int unsigned cyc, int unsigned idx);
    return cyc >= idx;
  endfunction

endpackage

// File: rtl/bbc_queue.sv
module bbc_queue #(
  parameter int QDEPTH = 2,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_dram,
  input  logic             pop,
  output logic             ready,
  output logic [CNT_W-1:0] count,
  output logic             head_dram
);

  logic             slot_q [QDEPTH];
  logic [CNT_W-1:0] wr_idx;

  assign ready  = int'(count) < QDEPTH;
  // The write slot follows the entries that survive this edge's pop.
  assign wr_idx = count - CNT_W'(pop);
  assign head_dram = slot_q[0];

  for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
    logic nxt;
    always_comb begin
      if (pop) nxt = (i + 1 < QDEPTH) ? slot_q[(i + 1) % QDEPTH] : 1'b0;
      else     nxt = slot_q[i];
      if (push && (wr_idx == CNT_W'(i))) nxt = push_dram;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[i] <= 1'b0;
      else        slot_q[i] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + CNT_W'(push) - CNT_W'(pop);
  end

endmodule

// File: rtl/bbc_fsm.sv
module bbc_fsm
  import bbc_pkg::*;
#(
  parameter int ACC_CYCLES = 3,
  localparam int CYC_W = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_gnt_n,
  input  logic             pre_done,
  input  logic             have_work,
  input  logic             more_work,
  input  logic             head_dram,
  output bbc_state_e       st,
  output logic [CYC_W-1:0] cyc,
  output logic             done_evt
);

  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(ACC_CYCLES - 1);

  bbc_state_e       st_nxt;
  logic [CYC_W-1:0] cyc_nxt;
  logic             gnt_seen;
  logic             last_cyc;

  assign gnt_seen = !bus_gnt_n;
  assign last_cyc = (cyc == LAST_CYC);

  // A job retires at the end of its access phase, or at precharge-done.
  assign done_evt = ((st == ST_ACCESS) && last_cyc && !head_dram) ||
                    ((st == ST_PRE) && pre_done);

  always_comb begin
    st_nxt  = st;
    cyc_nxt = cyc;
    unique case (st)
      ST_IDLE:    if (have_work) st_nxt = ST_REQ;
      ST_REQ:     if (gnt_seen) st_nxt = ST_GW1;
      ST_GW1:     st_nxt = gnt_seen ? ST_GW2 : ST_REQ;
      ST_GW2:     st_nxt = ST_DRIVE;
      ST_DRIVE: begin
        st_nxt  = ST_ACCESS;
        cyc_nxt = '0;
      end
      ST_ACCESS: begin
        if (!last_cyc)      cyc_nxt = cyc + 1'b1;
        else if (head_dram) st_nxt  = ST_PRE;
      end
      ST_PRE:     ;
      ST_RELEASE: st_nxt = ST_IDLE;
      default:    st_nxt = ST_IDLE;
    endcase
    if (done_evt) st_nxt = (more_work && gnt_seen) ? ST_DRIVE : ST_RELEASE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cyc <= '0;
    end else begin
      st  <= st_nxt;
      cyc <= cyc_nxt;
    end
  end

endmodule

// File: rtl/bbc_strobe.sv
module bbc_strobe
  import bbc_pkg::*;
#(
  parameter int NSTB  = 2,
  parameter int CYC_W = 2
) (
  input  bbc_state_e       st,
  input  logic [CYC_W-1:0] cyc,
  output logic [NSTB-1:0]  ctl_n,
  output logic             ctl_oe,
  output logic             bus_req_n
);

  logic in_access;

  assign in_access = (st == ST_ACCESS);
  assign ctl_oe    = drives_bus(st);
  assign bus_req_n = !holds_request(st);

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    assign ctl_n[g] = !(in_access && strobe_active(int'(cyc), g));
  end

endmodule

// File: rtl/bus_borrow_ctrl.sv
module bus_borrow_ctrl
  import bbc_pkg::*;
#(
  parameter int NSTB       = 2,
  parameter int ACC_CYCLES = 3,
  parameter int QDEPTH     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_req,
  input  logic            acc_dram,
  output logic            acc_ready,
  output logic            acc_ack,
  output logic            bus_req_n,
  input  logic            bus_gnt_n,
  output logic [NSTB-1:0] ctl_n,
  output logic            ctl_oe,
  input  logic            pre_done
);

  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam int CYC_W = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1;

  // Named internal events, also visible to the bound checker.
  bbc_state_e       st;
  logic [CYC_W-1:0] cyc;
  logic [CNT_W-1:0] pend_cnt;
  logic             take;
  logic             done_evt;
  logic             head_dram;
  logic             have_work;
  logic             more_work;

  assign take      = acc_req && acc_ready;
  assign have_work = (pend_cnt != '0) || take;
  assign more_work = work_after_pop(int'(pend_cnt), take);

  bbc_queue #(.QDEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (take),
    .push_dram (acc_dram),
    .pop       (done_evt),
    .ready     (acc_ready),
    .count     (pend_cnt),
    .head_dram (head_dram)
  );

  bbc_fsm #(.ACC_CYCLES(ACC_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_gnt_n (bus_gnt_n),
    .pre_done  (pre_done),
    .have_work (have_work),
    .more_work (more_work),
    .head_dram (head_dram),
    .st        (st),
    .cyc       (cyc),
    .done_evt  (done_evt)
  );

  bbc_strobe #(.NSTB(NSTB), .CYC_W(CYC_W)) u_strobe (
    .st        (st),
    .cyc       (cyc),
    .ctl_n     (ctl_n),
    .ctl_oe    (ctl_oe),
    .bus_req_n (bus_req_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_ack <= 1'b0;
    else        acc_ack <= done_evt;
  end

endmodule

// File: rtl/bbc_checker.sv
module bbc_checker
  import bbc_pkg::*;
#(
  parameter int NSTB   = 2,
  parameter int QDEPTH = 2,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req_n,
  input logic             bus_gnt_n,
  input logic             ctl_oe,
  input logic [NSTB-1:0]  ctl_n,
  input logic             acc_ack,
  input logic             pre_done,
  input bbc_state_e       st,
  input logic [CNT_W-1:0] pend_cnt
);

  // R1: idle means not driving
  a_r1_idle_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !ctl_oe);

  // R3: every rise of the enable follows two sampled grant edges
  a_r3_two_grant_samples: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_oe) |-> (!$past(bus_gnt_n, 2) && !$past(bus_gnt_n, 3)));

  // R5: active strobes only while driving and holding the request
  a_r5_strobe_needs_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ctl_n) |-> (ctl_oe && !bus_req_n));

  // R6: inactive strobes while the request is withdrawn
  a_r6_release_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && bus_req_n) |-> (&ctl_n));

  // R6: high-impedance one edge after the request rises
  a_r6_hiz_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_n) |=> !ctl_oe);

  // R7: precharge wait left only on pre_done
  a_r7_hold_for_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_PRE) && !pre_done) |=> (st == ST_PRE));

  // R8: acknowledge is a single-cycle pulse
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |=> !acc_ack);

  // R9: outstanding jobs bounded
  a_r9_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_cnt) <= QDEPTH);

endmodule

bind bus_borrow_ctrl bbc_checker #(.NSTB(NSTB), .QDEPTH(QDEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req_n (bus_req_n),
  .bus_gnt_n (bus_gnt_n),
  .ctl_oe    (ctl_oe),
  .ctl_n     (ctl_n),
  .acc_ack   (acc_ack),
  .pre_done  (pre_done),
  .st        (st),
  .pend_cnt  (pend_cnt)
);

// File: tb/sim_bus_borrow_ctrl.sv
module sim_bus_borrow_ctrl;
  localparam int NSTB = 2;
  localparam int ACC  = 3;
  localparam int QD   = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic            acc_req, acc_dram, bus_gnt_n, pre_done;
  logic            acc_ready, acc_ack, bus_req_n, ctl_oe;
  logic [NSTB-1:0] ctl_n;

  int errors = 0;
  int checks = 0;

  bus_borrow_ctrl #(.NSTB(NSTB), .ACC_CYCLES(ACC), .QDEPTH(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_dram(acc_dram),
    .acc_ready(acc_ready), .acc_ack(acc_ack), .bus_req_n(bus_req_n),
    .bus_gnt_n(bus_gnt_n), .ctl_n(ctl_n), .ctl_oe(ctl_oe), .pre_done(pre_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected strobe word in access cycle c: bit i low once c >= i.
  function automatic logic [NSTB-1:0] exp_pat(input int c);
    logic [NSTB-1:0] r;
    for (int i = 0; i < NSTB; i++) r[i] = (c >= i) ? 1'b0 : 1'b1;
    return r;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // Grant held from now: two sample edges, then inactive strobes driven.
  task automatic grant_path;
    bus_gnt_n = 1'b0;
    tick; chk(ctl_oe == 1'b0, "R3 no drive after first grant edge", int'(ctl_oe), 0);
    tick; chk(ctl_oe == 1'b0, "R3 no drive after second grant edge", int'(ctl_oe), 0);
    tick; chk(ctl_oe == 1'b1, "R3 drive on third edge", int'(ctl_oe), 1);
    chk(ctl_n == '1, "R3 strobes inactive when first driven", int'(ctl_n), (1 << NSTB) - 1);
  endtask

  task automatic access_cycles;
    for (int c = 0; c < ACC; c++) begin
      tick;
      chk(ctl_n == exp_pat(c), "R5 strobe pattern", int'(ctl_n), int'(exp_pat(c)));
      chk(bus_req_n == 1'b0, "R2 request held during access", int'(bus_req_n), 0);
    end
  endtask

  task automatic release_check(input string tag);
    chk(bus_req_n == 1'b1, {tag, " request withdrawn"}, int'(bus_req_n), 1);
    chk(ctl_oe == 1'b1 && ctl_n == '1, {tag, " inactive strobes still driven"}, int'(ctl_oe), 1);
    chk(acc_ack == 1'b1, "R8 ack on completion", int'(acc_ack), 1);
    bus_gnt_n = 1'b1;
    tick;
    chk(ctl_oe == 1'b0, "R6 high-impedance next edge", int'(ctl_oe), 0);
    chk(acc_ack == 1'b0, "R8 ack one cycle", int'(acc_ack), 0);
  endtask

  // Strobe-run monitor: each run of active strobes follows R5.
  int run = 0;
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n === 1'b1) begin
        if (ctl_n[0] == 1'b0) begin
          chk(ctl_n == exp_pat(run), "R5 monitor stagger", int'(ctl_n), int'(exp_pat(run)));
          run++;
        end else begin
          if (ctl_n != '1) chk(1'b0, "R5 monitor idle strobes", int'(ctl_n), (1 << NSTB) - 1);
          if (run != 0) chk(run == ACC, "R5 monitor access length", run, ACC);
          run = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int issued, acks, gdelay;
    void'($urandom(32'd2024));
    rst_n = 1'b0; acc_req = 1'b0; acc_dram = 1'b0; bus_gnt_n = 1'b1; pre_done = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    chk(bus_req_n == 1'b1, "R1 reset request", int'(bus_req_n), 1);
    chk(ctl_oe == 1'b0, "R1 reset enable", int'(ctl_oe), 0);
    chk(ctl_n == '1, "R1 reset strobes", int'(ctl_n), (1 << NSTB) - 1);
    chk(acc_ready == 1'b1 && acc_ack == 1'b0, "R1 reset port", int'(acc_ready), 1);

    // Single non-DRAM job
    acc_req = 1'b1; acc_dram = 1'b0;
    tick; acc_req = 1'b0;
    chk(bus_req_n == 1'b0, "R2 request after accept", int'(bus_req_n), 0);
    tick; tick;
    chk(bus_req_n == 1'b0 && ctl_oe == 1'b0, "R2 waiting for grant", int'(ctl_oe), 0);
    grant_path;
    access_cycles;
    tick; release_check("R6");

    // Short grant pulse ignored
    acc_req = 1'b1;
    tick; acc_req = 1'b0;
    bus_gnt_n = 1'b0;
    tick; bus_gnt_n = 1'b1;
    tick;
    chk(ctl_oe == 1'b0 && bus_req_n == 1'b0, "R4 short grant ignored", int'(ctl_oe), 0);
    tick; tick;
    chk(ctl_oe == 1'b0, "R4 still waiting", int'(ctl_oe), 0);
    grant_path;
    access_cycles;
    tick; release_check("R6");

    // DRAM job waits for precharge
    acc_req = 1'b1; acc_dram = 1'b1;
    tick; acc_req = 1'b0; acc_dram = 1'b0;
    grant_path;
    access_cycles;
    for (int i = 0; i < 3; i++) begin
      tick;
      chk(ctl_oe == 1'b1 && ctl_n == '1 && bus_req_n == 1'b0, "R7 hold for precharge",
          int'(bus_req_n), 0);
      chk(acc_ack == 1'b0, "R7 no ack before precharge", int'(acc_ack), 0);
    end
    pre_done = 1'b1;
    tick; pre_done = 1'b0;
    release_check("R7");

    // Two queued jobs chained, third dropped
    acc_req = 1'b1;
    tick;
    chk(acc_ready == 1'b1, "R9 room after one", int'(acc_ready), 1);
    tick;
    chk(acc_ready == 1'b0, "R9 full after two", int'(acc_ready), 0);
    tick; acc_req = 1'b0;
    grant_path;
    access_cycles;
    tick;
    chk(bus_req_n == 1'b0 && ctl_oe == 1'b1 && ctl_n == '1, "R10 chained without release",
        int'(bus_req_n), 0);
    chk(acc_ack == 1'b1, "R10 ack first of chain", int'(acc_ack), 1);
    access_cycles;
    tick; release_check("R10");
    tick; tick;
    chk(bus_req_n == 1'b1, "R9 dropped request left no job", int'(bus_req_n), 1);

    // Grant lost with work pending
    acc_req = 1'b1;
    tick; tick; acc_req = 1'b0;
    grant_path;
    access_cycles;
    bus_gnt_n = 1'b1;
    tick;
    chk(bus_req_n == 1'b1 && ctl_oe == 1'b1 && acc_ack == 1'b1, "R11 release on lost grant",
        int'(bus_req_n), 1);
    tick;
    chk(ctl_oe == 1'b0 && bus_req_n == 1'b1, "R11 high-impedance", int'(ctl_oe), 0);
    tick;
    chk(bus_req_n == 1'b0, "R11 re-arbitrates", int'(bus_req_n), 0);
    grant_path;
    access_cycles;
    tick; release_check("R11");

    // Random traffic, grant and precharge timing
    issued = 0; acks = 0; gdelay = 2;
    for (int cy = 0; cy < 20000; cy++) begin
      tick;
      if (acc_ack) acks++;
      if (issued == 40 && acks == issued && bus_req_n && !ctl_oe) break;
      acc_req  = (issued < 40) && ($urandom % 4 == 0);
      acc_dram = $urandom % 2;
      if (acc_req && acc_ready) issued++;
      if (bus_req_n == 1'b0) begin
        if (bus_gnt_n == 1'b1) begin
          if (gdelay == 0) bus_gnt_n = 1'b0;
          else gdelay--;
        end else if ($urandom % 16 == 0) begin
          bus_gnt_n = 1'b1;
          gdelay = $urandom % 4;
        end
      end else begin
        bus_gnt_n = 1'b1;
        gdelay = $urandom % 4;
      end
      pre_done = ($urandom % 3 == 0);
    end
    acc_req = 1'b0; pre_done = 1'b0; bus_gnt_n = 1'b1;
    chk(acks == issued, "R8 acks match accepted jobs", acks, issued);
    chk(issued == 40, "R9 random jobs accepted", issued, 40);
    tick; tick;
    chk(ctl_oe == 1'b0 && bus_req_n == 1'b1, "R1 idle after traffic", int'(ctl_oe), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule